// File: doc/BRIEF.md
# Distributed-Arithmetic FIR Look-Up Table Reloader

This block fills the partial-product look-up tables of a small distributed-arithmetic FIR filter. The tables hold precomputed sums of coefficient subsets, not raw taps. Entry zero of every table is the empty sum, so the first word of every load must be zero. A loader in its own reload clock raises a write enable and then streams words. The enable must lead the first real word by a mode-dependent number of cycles: two in serial mode and one in parallel mode. Words presented during those lead cycles are dropped. The following words go to consecutive table addresses, starting at zero, in the bank chosen when the enable rose.

The filter runs in a second, possibly unrelated clock. It reads the active bank. It forms the table address from one input bit per tap, so four taps address sixteen entries. The filter asks for a bank through its own select input. The block moves the filter onto that bank only after any load into it has finished. The busy state of each bank reaches the filter clock through a two-flop synchronizer. A sticky flag reports a load whose first written word was not zero.

Top module: `da_coef_reloader`

## Requirements
- R1: With SERIAL_MODE=1, the first two reload-clock cycles with the enable high carry no data. The word in the third high cycle is written to address 0.
- R2: With SERIAL_MODE=0, only the first high cycle carries no data. The word in the second high cycle is written to address 0.
- R3: Each later high cycle writes to the next address (address + 1). Once all 2^TAPS addresses have been written, further words in the same load are dropped and the table is unchanged.
- R4: One reload-clock cycle with the enable low ends a load. The next rise starts over with fresh lead cycles at address 0.
- R5: The bank a load writes is the value of wr_bank in the cycle the enable rises. Changes to wr_bank later in the same load have no effect.
- R6: zero_err rises when the first word written by a load is non-zero. It then stays high until reload-domain reset, including across later loads that start with zero.
- R7: On each filter-clock edge, rd_word takes the entry of the active bank at address rd_bits, where bit i of rd_bits is tap i's input bit. The result appears one filter-clock cycle later.
- R8: rd_bank follows rd_bank_sel, but never switches to a bank whose load is still in progress as seen through the two-flop synchronizer. It switches within a few filter cycles after that load ends.
- R9: After reset, rd_word, rd_bank and zero_err are 0 and every table entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Reload clock |
| wrst_n | input | 1 | Reload-domain asynchronous reset, active low |
| wr_en | input | 1 | Load enable; high across lead cycles and data |
| wr_bank | input | BANK_W | Target bank, taken when the enable rises |
| wr_data | input | WORD_W | Precomputed partial-product word |
| fclk | input | 1 | Filter clock |
| frst_n | input | 1 | Filter-domain asynchronous reset, active low |
| rd_bank_sel | input | BANK_W | Bank the filter asks to read |
| rd_bits | input | TAPS | One input bit per tap, used as the table address |
| rd_word | output | WORD_W | Registered table output |
| rd_bank | output | BANK_W | Bank the filter is reading now |
| zero_err | output | 1 | Sticky flag for a non-zero first word |

## Verification
A wrong lead count or address counter shifts a whole table by one entry. The bank is swept with every rd_bits value, so this shows on rd_word within sixteen filter cycles of the first sweep after the load. A wrongly latched target bank corrupts the other bank, which shows on the sweep of that bank. A lost sticky bit shows on zero_err on the next reload-clock edge. A missing or bypassed busy check shows as rd_bank moving early during a long load, one filter cycle after the select changes.

// File: rtl/da_reload_pkg.sv
package da_reload_pkg;

    typedef enum logic [1:0] {
        PH_ARMED = 2'd0,
        PH_LEAD  = 2'd1,
        PH_LOAD  = 2'd2
    } ld_phase_e;

    // Lead cycles between the enable rising and the first data word.
    function automatic int lead_of(input bit serial);
        return serial ? 2 : 1;
    endfunction

endpackage

// File: rtl/da_load_seq.sv
module da_load_seq
    import da_reload_pkg::*;
#(
    parameter int TAPS        = 4,
    parameter int WORD_W      = 12,
    parameter int NBANKS      = 2,
    parameter int SERIAL_MODE = 1,
    localparam int BANK_W     = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [WORD_W-1:0] wr_data,
    output logic              we,
    output logic [TAPS-1:0]   waddr,
    output logic [BANK_W-1:0] wbank,
    output logic [NBANKS-1:0] lock,
    output logic              err
);
    localparam int         LEAD   = lead_of(SERIAL_MODE != 0);
    localparam logic [1:0] LEAD_C = 2'(LEAD);
    localparam logic [TAPS:0] ONE_A = {{TAPS{1'b0}}, 1'b1};

    typedef struct packed {
        ld_phase_e         ph;
        logic [1:0]        cnt;
        logic [TAPS:0]     addr;
        logic [BANK_W-1:0] bank;
        logic [NBANKS-1:0] lock;
        logic              err;
    } seq_t;

    seq_t st_d, st_q;
    logic we_d;

    always_comb begin
        st_d = st_q;
        we_d = 1'b0;
        case (st_q.ph)
            PH_ARMED: begin
                if (wr_en) begin
                    st_d.bank          = wr_bank;
                    st_d.lock[wr_bank] = 1'b1;
                    st_d.cnt           = 2'd1;
                    st_d.ph            = (LEAD_C == 2'd1) ? PH_LOAD : PH_LEAD;
                end
            end
            PH_LEAD: begin
                if (!wr_en) begin
                    st_d.ph              = PH_ARMED;
                    st_d.cnt             = 2'd0;
                    st_d.addr            = '0;
                    st_d.lock[st_q.bank] = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + 2'd1;
                    if (st_d.cnt == LEAD_C) st_d.ph = PH_LOAD;
                end
            end
            default: begin
                if (!wr_en) begin
                    st_d.ph              = PH_ARMED;
                    st_d.cnt             = 2'd0;
                    st_d.addr            = '0;
                    st_d.lock[st_q.bank] = 1'b0;
                end else if (!st_q.addr[TAPS]) begin
                    we_d      = 1'b1;
                    st_d.addr = st_q.addr + ONE_A;
                    if (st_q.addr == '0 && wr_data != '0) st_d.err = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            st_q <= '{ph: PH_ARMED, cnt: 2'd0, addr: '0, bank: '0, lock: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign we    = we_d;
    assign waddr = st_q.addr[TAPS-1:0];
    assign wbank = st_q.bank;
    assign lock  = st_q.lock;
    assign err   = st_q.err;

endmodule

// File: rtl/da_lut_banks.sv
module da_lut_banks #(
    parameter int TAPS     = 4,
    parameter int WORD_W   = 12,
    parameter int NBANKS   = 2,
    localparam int BANK_W  = (NBANKS > 1) ? $clog2(NBANKS) : 1,
    localparam int DEPTH   = 1 << TAPS
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] wbank,
    input  logic [TAPS-1:0]   waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BANK_W-1:0] rbank,
    input  logic [TAPS-1:0]   raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] tbl_q [NBANKS][DEPTH];

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        always_ff @(posedge wclk or negedge wrst_n) begin
            if (!wrst_n) begin
                for (int e = 0; e < DEPTH; e++) tbl_q[b][e] <= '0;
            end else if (we && wbank == BANK_W'(b)) begin
                tbl_q[b][waddr] <= wdata;
            end
        end
    end

    assign rdata = tbl_q[rbank][raddr];

endmodule

// File: rtl/da_bank_xfer.sv
module da_bank_xfer #(
    parameter int TAPS     = 4,
    parameter int WORD_W   = 12,
    parameter int NBANKS   = 2,
    localparam int BANK_W  = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic              fclk,
    input  logic              frst_n,
    input  logic [NBANKS-1:0] lock_w,
    input  logic [BANK_W-1:0] rd_bank_sel,
    input  logic [WORD_W-1:0] tbl_word,
    output logic [BANK_W-1:0] act_bank,
    output logic [WORD_W-1:0] rd_word,
    output logic [NBANKS-1:0] lock_f
);
    typedef struct packed {
        logic [NBANKS-1:0] s1;
        logic [NBANKS-1:0] s2;
        logic [BANK_W-1:0] act;
        logic [WORD_W-1:0] word;
    } xf_t;

    xf_t xf_d, xf_q;

    always_comb begin
        xf_d      = xf_q;
        xf_d.s1   = lock_w;
        xf_d.s2   = xf_q.s1;
        xf_d.act  = xf_q.s2[rd_bank_sel] ? xf_q.act : rd_bank_sel;
        xf_d.word = tbl_word;
    end

    always_ff @(posedge fclk or negedge frst_n) begin
        if (!frst_n) xf_q <= '0;
        else         xf_q <= xf_d;
    end

    assign act_bank = xf_q.act;
    assign rd_word  = xf_q.word;
    assign lock_f   = xf_q.s2;

endmodule

// File: rtl/da_coef_reloader.sv
module da_coef_reloader #(
    parameter int TAPS        = 4,
    parameter int WORD_W      = 12,
    parameter int NBANKS      = 2,
    parameter int SERIAL_MODE = 1,
    localparam int BANK_W     = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              fclk,
    input  logic              frst_n,
    input  logic [BANK_W-1:0] rd_bank_sel,
    input  logic [TAPS-1:0]   rd_bits,
    output logic [WORD_W-1:0] rd_word,
    output logic [BANK_W-1:0] rd_bank,
    output logic              zero_err
);
    logic              we_w;
    logic [TAPS-1:0]   waddr_w;
    logic [BANK_W-1:0] wbank_w;
    logic [NBANKS-1:0] lock_w;
    logic [NBANKS-1:0] lock_sync;
    logic [WORD_W-1:0] tbl_word;

    da_load_seq #(
        .TAPS(TAPS), .WORD_W(WORD_W), .NBANKS(NBANKS), .SERIAL_MODE(SERIAL_MODE)
    ) u_seq (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_data(wr_data), .we(we_w), .waddr(waddr_w), .wbank(wbank_w),
        .lock(lock_w), .err(zero_err)
    );

    da_lut_banks #(
        .TAPS(TAPS), .WORD_W(WORD_W), .NBANKS(NBANKS)
    ) u_tbl (
        .wclk(wclk), .wrst_n(wrst_n), .we(we_w), .wbank(wbank_w),
        .waddr(waddr_w), .wdata(wr_data), .rbank(rd_bank),
        .raddr(rd_bits), .rdata(tbl_word)
    );

    da_bank_xfer #(
        .TAPS(TAPS), .WORD_W(WORD_W), .NBANKS(NBANKS)
    ) u_xfer (
        .fclk(fclk), .frst_n(frst_n), .lock_w(lock_w),
        .rd_bank_sel(rd_bank_sel), .tbl_word(tbl_word),
        .act_bank(rd_bank), .rd_word(rd_word), .lock_f(lock_sync)
    );

endmodule

// File: rtl/da_coef_reloader_chk.sv
module da_coef_reloader_chk #(
    parameter int TAPS        = 4,
    parameter int NBANKS      = 2,
    parameter int SERIAL_MODE = 1,
    localparam int BANK_W     = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input logic              wclk,
    input logic              wrst_n,
    input logic              fclk,
    input logic              frst_n,
    input logic              wr_en,
    input logic              we_w,
    input logic [TAPS-1:0]   waddr_w,
    input logic [BANK_W-1:0] wbank_w,
    input logic [NBANKS-1:0] lock_w,
    input logic [NBANKS-1:0] lock_sync,
    input logic [BANK_W-1:0] rd_bank,
    input logic              zero_err
);
    // R1 / R2: a write is always preceded by at least one lead cycle
    p_lead_one_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
        we_w |-> $past(wr_en));

    if (SERIAL_MODE != 0) begin : g_serial
        // R1: serial mode needs two lead cycles
        p_lead_two_r1: assert property (@(posedge wclk) disable iff (!wrst_n)
            we_w |-> ($past(wr_en) && $past(wr_en, 2)));
    end

    // R3: back-to-back writes step the address by one
    p_addr_step_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
        (we_w && $past(we_w)) |-> (waddr_w == $past(waddr_w) + 1'b1));

    // R4: a low enable cycle is never followed directly by a write
    p_rearm_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
        !wr_en |=> !we_w);

    // R5: the target bank does not move within a load
    p_bank_hold_r5: assert property (@(posedge wclk) disable iff (!wrst_n)
        (we_w && $past(we_w)) |-> (wbank_w == $past(wbank_w)));

    // R6: error flag is sticky
    p_err_sticky_r6: assert property (@(posedge wclk) disable iff (!wrst_n)
        zero_err |=> zero_err);

    // R8: written bank is marked busy
    p_write_locked_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
        we_w |-> lock_w[wbank_w]);

    // R8: the filter never moves onto a bank it sees as busy
    p_no_busy_switch_r8: assert property (@(posedge fclk) disable iff (!frst_n)
        (rd_bank != $past(rd_bank)) |-> !lock_sync[rd_bank]);

endmodule

bind da_coef_reloader da_coef_reloader_chk #(
    .TAPS(TAPS), .NBANKS(NBANKS), .SERIAL_MODE(SERIAL_MODE)
) u_chk (
    .wclk(wclk), .wrst_n(wrst_n), .fclk(fclk), .frst_n(frst_n),
    .wr_en(wr_en), .we_w(we_w), .waddr_w(waddr_w), .wbank_w(wbank_w),
    .lock_w(lock_w), .lock_sync(lock_sync), .rd_bank(rd_bank),
    .zero_err(zero_err)
);

// File: tb/tb_da_coef_reloader.sv
`timescale 1ns/1ps
module tb_da_coef_reloader;
    localparam int TAPS = 4, WW = 12, DEP = 16;

    logic wclk = 1'b0, fclk = 1'b0;
    logic wrst_n = 1'b0, frst_n = 1'b0;
    logic wr_en = 1'b0, wr_bank = 1'b0, rd_bank_sel = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic [TAPS-1:0] rd_bits = '0, bits_cap = '0;
    logic [WW-1:0] rw_s, rw_p;
    logic rb_s, rb_p, ze_s, ze_p;

    always #4 wclk = ~wclk;   // 125 MHz reload clock
    always #6 fclk = ~fclk;   // filter clock

    da_coef_reloader #(.TAPS(TAPS), .WORD_W(WW), .NBANKS(2), .SERIAL_MODE(1)) dut (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_data(wr_data),
        .fclk(fclk), .frst_n(frst_n), .rd_bank_sel(rd_bank_sel), .rd_bits(rd_bits),
        .rd_word(rw_s), .rd_bank(rb_s), .zero_err(ze_s));

    da_coef_reloader #(.TAPS(TAPS), .WORD_W(WW), .NBANKS(2), .SERIAL_MODE(0)) dut_par (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_data(wr_data),
        .fclk(fclk), .frst_n(frst_n), .rd_bank_sel(rd_bank_sel), .rd_bits(rd_bits),
        .rd_word(rw_p), .rd_bank(rb_p), .zero_err(ze_p));

    int n_chk = 0, n_bad = 0;
    logic cmp_on = 1'b0;
    string lbl = "R9";

    // Behavioural reference: index 0 serial (lead 2), 1 parallel (lead 1)
    logic [WW-1:0] mdl [2][2][DEP];
    logic mbank [2];
    logic merr [2];
    int hi_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge wclk) begin
        if (!wrst_n) begin
            for (int m = 0; m < 2; m++) begin
                merr[m] = 1'b0; mbank[m] = 1'b0;
                for (int b = 0; b < 2; b++)
                    for (int e = 0; e < DEP; e++) mdl[m][b][e] = '0;
            end
            hi_cnt = 0;
        end else if (wr_en) begin
            for (int m = 0; m < 2; m++) begin
                int idx;
                idx = hi_cnt - ((m == 0) ? 2 : 1);
                if (hi_cnt == 0) mbank[m] = wr_bank;
                if (idx >= 0 && idx < DEP) mdl[m][mbank[m]][idx] = wr_data;
                if (idx == 0 && wr_data != '0) merr[m] = 1'b1;
            end
            hi_cnt++;
        end else begin
            hi_cnt = 0;
        end
    end

    always @(negedge wclk) if (wrst_n) begin
        chk(ze_s == merr[0], "R6", ze_s, merr[0]);
        chk(ze_p == merr[1], "R6", ze_p, merr[1]);
    end

    always @(posedge fclk) bits_cap <= rd_bits;
    always @(negedge fclk) begin
        if (cmp_on) begin
            chk(rw_s == mdl[0][rd_bank_sel][bits_cap], {lbl, " R7 serial"},
                rw_s, mdl[0][rd_bank_sel][bits_cap]);
            chk(rw_p == mdl[1][rd_bank_sel][bits_cap], {lbl, " R7 parallel"},
                rw_p, mdl[1][rd_bank_sel][bits_cap]);
            chk(rb_s == rd_bank_sel && rb_p == rd_bank_sel, "R8", rb_s, rd_bank_sel);
        end
        rd_bits <= rd_bits + 1'b1;
    end

    // Hold the enable n cycles; slot 0 junk, slots 1 and 2 = fv, then a ramp
    task automatic load(input int n, input logic b0, input logic b1,
                        input logic [WW-1:0] fv, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_en   = 1'b1;
            wr_bank = (i < 3) ? b0 : b1;
            wr_data = (i == 0) ? 12'h5A5 : (i < 3) ? fv : WW'(base + i * 7);
        end
        @(negedge wclk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic quiet(input logic s, input string l, input int n);
        cmp_on = 1'b0;
        @(negedge fclk); rd_bank_sel = s;
        repeat (6) @(negedge fclk);
        lbl = l; cmp_on = 1'b1;
        repeat (n) @(negedge fclk);
        cmp_on = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        summary();
    end

    initial begin
        repeat (4) @(negedge wclk);
        wrst_n = 1'b1; frst_n = 1'b1;
        repeat (3) @(negedge fclk);
        chk(rw_s == 0 && rw_p == 0, "R9", rw_s, 0);
        chk(rb_s == 0 && rb_p == 0, "R9", rb_s, 0);
        chk(ze_s == 0 && ze_p == 0, "R9", ze_s, 0);
        quiet(1'b0, "R9", 20);
        quiet(1'b1, "R9", 20);

        // R1 R2 R3: lead handling, sequential fill, overflow dropped
        load(22, 1'b0, 1'b0, 12'h000, 100);
        quiet(1'b0, "R1 R2 R3", 34);

        // R3: exact fill of bank 1 then overflow
        load(25, 1'b1, 1'b1, 12'h000, 400);
        quiet(1'b1, "R3", 34);

        // R4: one low cycle between two loads
        load(10, 1'b1, 1'b1, 12'h000, 700);
        load(8, 1'b0, 1'b0, 12'h000, 900);
        quiet(1'b0, "R4", 34);
        quiet(1'b1, "R4", 34);

        // R5: wr_bank flips mid-load, must be ignored
        load(12, 1'b1, 1'b0, 12'h000, 1200);
        quiet(1'b1, "R5", 34);
        quiet(1'b0, "R5", 34);

        // R6: non-zero first word, then a clean load keeps the flag
        chk(ze_s == 0 && ze_p == 0, "R6", ze_s, 0);
        load(6, 1'b0, 1'b0, 12'h111, 1500);
        repeat (2) @(negedge wclk);
        chk(ze_s == 1 && ze_p == 1, "R6", {ze_s, ze_p}, 3);
        load(6, 1'b0, 1'b0, 12'h000, 1600);
        repeat (2) @(negedge wclk);
        chk(ze_s == 1 && ze_p == 1, "R6", {ze_s, ze_p}, 3);
        quiet(1'b0, "R6", 20);

        // R8: request a bank while it is being loaded
        fork
            load(30, 1'b1, 1'b1, 12'h000, 2000);
            begin
                repeat (6) @(negedge fclk);
                rd_bank_sel = 1'b1;
                repeat (8) begin
                    @(negedge fclk);
                    chk(rb_s == 0 && rb_p == 0, "R8", {rb_s, rb_p}, 0);
                end
            end
        join
        repeat (6) @(negedge fclk);
        chk(rb_s == 1 && rb_p == 1, "R8", {rb_s, rb_p}, 3);
        quiet(1'b1, "R8", 34);
        quiet(1'b0, "R8", 20);

        summary();
    end
endmodule